// File: doc/BRIEF.md
# Coherence State Controller for a Writeback Data Cache

This block owns the coherence state of a small direct-mapped writeback data cache of 16 lines. Each line holds a physical tag and a two-bit state (Invalid, Shared, Exclusive, Modified). The block answers snoop lookups that come from the external bus or from inside the core. It also carries out three cache-wide commands: a flush strobe, a writeback-and-invalidate strobe and an invalidate-only strobe. Line replacement enters through its own port, which installs a new tag and state into a chosen line.

Whenever a Modified line must give up its data, the block first writes the whole 32-byte line to the bus. The writeback is a burst of four 64-bit beats, and each beat waits for an acknowledge. The kind of event decides the state that follows. An external inquire without the invalidate bit leaves a hit line Shared. Internal snoops and both walking commands leave it Invalid. The invalidate-only command discards every line at once, Modified data included, and writes nothing back.

Requests are accepted only while the ready output is high, which means the controller is idle. Snoop results appear as a one-cycle response strobe in the cycle after the request. The flush and writeback-and-invalidate commands step through the lines in ascending index order. Busy stays high for the whole walk, and done pulses once when the walk ends.

Top module: `mesi_snoop_ctrl`

The controller states are IDLE, SNP_WB (snoop writeback), WALK (scan one line), WALK_WB (walk writeback) and REPL_WB (victim writeback). The transitions are:
- IDLE to SNP_WB when a snoop hits a Modified line.
- IDLE to WALK when flush or writeback-and-invalidate is seen.
- IDLE to REPL_WB when a replacement victim is Modified.
- WALK to WALK_WB when the scanned line is Modified.
- WALK_WB back to WALK when the burst ends, and to IDLE if that was the last line.
- WALK to IDLE after the last line.
- SNP_WB to IDLE and REPL_WB to IDLE when the burst ends.

## Requirements
- R1: After reset every line is Invalid, `req_rdy_o` is 1, and `busy_o`, `done_o`, `wb_valid_o` and `rsp_valid_o` are 0.
- R2: An external inquire (`snp_internal_i`=0) that hits a Shared or Exclusive line gives `rsp_hit_o`=1 and `rsp_hitm_o`=0 in the next cycle, with no writeback. The line becomes Shared when `snp_inv_i`=0 and Invalid when `snp_inv_i`=1.
- R3: An external inquire that hits a Modified line gives `rsp_hitm_o`=1 and `rsp_hit_o`=1 in the next cycle. The line is then written back, and only after that does it become Shared (`snp_inv_i`=0) or Invalid (`snp_inv_i`=1).
- R4: An internal snoop (`snp_internal_i`=1) hit always leaves the line Invalid, whatever `snp_inv_i` is. A Modified line is written back first.
- R5: A snoop whose tag differs from the stored tag, or whose line is Invalid, reports a miss. It changes no state and starts no writeback.
- R6: A writeback sends 4 beats at line base, base+8, base+16 and base+24. The base is {tag, index, 5'b0}, with address bits [8:5] as the index and [31:9] as the tag. A beat holds its address until it is acknowledged, and `wb_last_o` marks the fourth beat.
- R7: Flush or writeback-and-invalidate writes back every Modified line in ascending index order and leaves all lines Invalid. `busy_o` is high during the walk, and `done_o` pulses high for exactly one cycle after it.
- R8: Invalidate-only makes every line Invalid at the next clock edge with no bus beats, even for Modified lines.
- R9: A replacement whose victim is Modified writes the victim back before it installs `repl_tag_i` and `repl_state_i`. A Shared or Exclusive victim is replaced with no beats.
- R10: While a writeback or walk is in progress `req_rdy_o` is 0, and any snoop, command or replacement presented then is ignored.
- R11: When several requests arrive in the same idle cycle the priority is snoop, then invalidate-only, then flush or writeback-and-invalidate, then replacement. Lower-priority requests in that cycle are dropped.
- R12: `rsp_state_o` reports the line state before the snoop, encoded I=2'b00, S=2'b01, E=2'b10, M=2'b11. A miss reports 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| snp_valid_i | input | 1 | Snoop request strobe |
| snp_addr_i | input | 32 | Physical snoop address |
| snp_inv_i | input | 1 | Invalidate request bit of an external inquire |
| snp_internal_i | input | 1 | 1 = internal snoop, 0 = external inquire |
| req_rdy_o | output | 1 | Controller idle, requests accepted |
| rsp_valid_o | output | 1 | Snoop response strobe |
| rsp_hit_o | output | 1 | Snoop hit a valid line |
| rsp_hitm_o | output | 1 | Snoop hit a Modified line |
| rsp_state_o | output | 2 | Line state before the snoop |
| flush_i | input | 1 | Flush strobe |
| wbinvd_i | input | 1 | Writeback-and-invalidate strobe |
| invd_i | input | 1 | Invalidate-only strobe |
| repl_valid_i | input | 1 | Replacement request |
| repl_idx_i | input | 4 | Line index to replace |
| repl_tag_i | input | 23 | New tag for the line |
| repl_state_i | input | 2 | New state for the line |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle walk completion pulse |
| wb_valid_o | output | 1 | Writeback beat valid |
| wb_addr_o | output | 32 | Writeback beat address |
| wb_last_o | output | 1 | Last beat of the burst |
| wb_ack_i | input | 1 | Beat acknowledge |

## Verification
A corrupted state bit in the store shows up on the very next snoop to that line. It appears as a wrong `rsp_state_o` code, a hit where a miss is due, or a writeback burst that should not be there, one cycle after the request. A wrong FSM state or walk index shows within a few cycles as beats in the wrong order or at wrong addresses, a stuck `req_rdy_o`, or a missing or repeated `done_o` pulse. The bench therefore follows every state change with a probing snoop, and it matches every bus beat against a queue of expected addresses.

// File: rtl/mesi_snoop_pkg.sv
package mesi_snoop_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_st_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SNP_WB,
        ST_WALK,
        ST_WALK_WB,
        ST_REPL_WB
    } ctrl_st_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_snoop_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int TAG_W     = 23,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IDX_W-1:0] a_idx_i,
    output logic [TAG_W-1:0] a_tag_o,
    output line_st_e         a_st_o,
    input  logic [IDX_W-1:0] b_idx_i,
    output logic [TAG_W-1:0] b_tag_o,
    output line_st_e         b_st_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             wr_tag_en_i,
    input  logic [TAG_W-1:0] wr_tag_i,
    input  line_st_e         wr_st_i,
    input  logic             clr_all_i
);
    line_st_e             st_q  [NUM_LINES];
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic [NUM_LINES-1:0] vld_vec;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                st_q[i]  <= LS_INV;
                tag_q[i] <= '0;
            end
        end else if (clr_all_i) begin
            for (int i = 0; i < NUM_LINES; i++) st_q[i] <= LS_INV;
        end else if (wr_en_i) begin
            st_q[wr_idx_i] <= wr_st_i;
            if (wr_tag_en_i) tag_q[wr_idx_i] <= wr_tag_i;
        end
    end

    assign a_tag_o = tag_q[a_idx_i];
    assign a_st_o  = st_q[a_idx_i];
    assign b_tag_o = tag_q[b_idx_i];
    assign b_st_o  = st_q[b_idx_i];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_vld
        assign vld_vec[g] = (st_q[g] != LS_INV);
    end

    AST_CLR_LEAVES_NONE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_all_i |=> (vld_vec == '0)); // R8
endmodule

// File: rtl/mesi_wb_burst.sv
module mesi_wb_burst #(
    parameter int ADDR_W     = 32,
    parameter int BEATS      = 4,
    parameter int BEAT_BYTES = 8,
    localparam int BC_W      = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              wb_valid_o,
    output logic [ADDR_W-1:0] wb_addr_o,
    output logic              wb_last_o,
    input  logic              wb_ack_i,
    output logic              done_o
);
    logic              act_q;
    logic [BC_W-1:0]   beat_q;
    logic [ADDR_W-1:0] base_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            act_q  <= 1'b0;
            beat_q <= '0;
            base_q <= '0;
        end else if (start_i) begin
            act_q  <= 1'b1;
            beat_q <= '0;
            base_q <= base_i;
        end else if (act_q && wb_ack_i) begin
            if (wb_last_o) act_q <= 1'b0;
            else           beat_q <= beat_q + 1'b1;
        end
    end

    assign wb_valid_o = act_q;
    assign wb_last_o  = act_q && (beat_q == BC_W'(BEATS - 1));
    assign wb_addr_o  = base_q + ADDR_W'(beat_q) * ADDR_W'(BEAT_BYTES);
    assign done_o     = act_q && wb_ack_i && wb_last_o;

    AST_BEAT_HELD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_o && !wb_ack_i) |=> (wb_valid_o && $stable(wb_addr_o))); // R6
    AST_BEAT_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wb_valid_o && wb_ack_i && !wb_last_o) |=> (wb_addr_o == $past(wb_addr_o) + ADDR_W'(BEAT_BYTES))); // R6
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_snoop_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_LINES  = 16,
    parameter int LINE_BYTES = 32,
    parameter int BEAT_BYTES = 8
) (
    input  logic                                                   clk_i,
    input  logic                                                   rst_ni,
    input  logic                                                   snp_valid_i,
    input  logic [ADDR_W-1:0]                                      snp_addr_i,
    input  logic                                                   snp_inv_i,
    input  logic                                                   snp_internal_i,
    output logic                                                   req_rdy_o,
    output logic                                                   rsp_valid_o,
    output logic                                                   rsp_hit_o,
    output logic                                                   rsp_hitm_o,
    output logic [1:0]                                             rsp_state_o,
    input  logic                                                   flush_i,
    input  logic                                                   wbinvd_i,
    input  logic                                                   invd_i,
    input  logic                                                   repl_valid_i,
    input  logic [$clog2(NUM_LINES)-1:0]                           repl_idx_i,
    input  logic [ADDR_W-$clog2(NUM_LINES)-$clog2(LINE_BYTES)-1:0] repl_tag_i,
    input  logic [1:0]                                             repl_state_i,
    output logic                                                   busy_o,
    output logic                                                   done_o,
    output logic                                                   wb_valid_o,
    output logic [ADDR_W-1:0]                                      wb_addr_o,
    output logic                                                   wb_last_o,
    input  logic                                                   wb_ack_i
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int BEATS = LINE_BYTES / BEAT_BYTES;

    ctrl_st_e         state_q, state_d;
    logic [IDX_W-1:0] op_idx_q, op_idx_d;
    line_st_e         op_st_q, op_st_d;
    logic [TAG_W-1:0] op_tag_q, op_tag_d;
    logic             done_d;
    logic             rsp_vld_q, rsp_hit_q, rsp_hitm_q;
    line_st_e         rsp_st_q;

    logic [IDX_W-1:0] snp_idx, b_idx;
    logic [TAG_W-1:0] snp_tag, a_tag, b_tag;
    line_st_e         a_st, b_st, snp_new_st;
    logic             snp_hit, snp_take;
    logic             wr_en, wr_tag_en, clr_all;
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    line_st_e         wr_st;
    logic             bst_start, bst_done;
    logic [ADDR_W-1:0] bst_base;
    logic             walk_last;

    assign snp_idx    = snp_addr_i[OFF_W +: IDX_W];
    assign snp_tag    = snp_addr_i[ADDR_W-1 -: TAG_W];
    assign snp_hit    = (a_st != LS_INV) && (a_tag == snp_tag);
    assign snp_new_st = (snp_internal_i || snp_inv_i) ? LS_INV : LS_SHR;
    assign snp_take   = (state_q == ST_IDLE) && snp_valid_i;
    assign b_idx      = (state_q == ST_IDLE) ? repl_idx_i : op_idx_q;
    assign walk_last  = (op_idx_q == IDX_W'(NUM_LINES - 1));

    mesi_line_store #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_store (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .a_idx_i(snp_idx), .a_tag_o(a_tag), .a_st_o(a_st),
        .b_idx_i(b_idx), .b_tag_o(b_tag), .b_st_o(b_st),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_en_i(wr_tag_en),
        .wr_tag_i(wr_tag), .wr_st_i(wr_st), .clr_all_i(clr_all)
    );

    mesi_wb_burst #(.ADDR_W(ADDR_W), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES)) u_burst (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .start_i(bst_start), .base_i(bst_base),
        .wb_valid_o(wb_valid_o), .wb_addr_o(wb_addr_o), .wb_last_o(wb_last_o),
        .wb_ack_i(wb_ack_i), .done_o(bst_done)
    );

    // State register and captured operation context
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q    <= ST_IDLE;
            op_idx_q   <= '0;
            op_st_q    <= LS_INV;
            op_tag_q   <= '0;
            done_o     <= 1'b0;
            rsp_vld_q  <= 1'b0;
            rsp_hit_q  <= 1'b0;
            rsp_hitm_q <= 1'b0;
            rsp_st_q   <= LS_INV;
        end else begin
            state_q    <= state_d;
            op_idx_q   <= op_idx_d;
            op_st_q    <= op_st_d;
            op_tag_q   <= op_tag_d;
            done_o     <= done_d;
            rsp_vld_q  <= snp_take;
            rsp_hit_q  <= snp_take && snp_hit;
            rsp_hitm_q <= snp_take && snp_hit && (a_st == LS_MOD);
            rsp_st_q   <= (snp_take && snp_hit) ? a_st : LS_INV;
        end
    end

    // Next state, store writes and burst control
    always_comb begin
        state_d   = state_q;
        op_idx_d  = op_idx_q;
        op_st_d   = op_st_q;
        op_tag_d  = op_tag_q;
        done_d    = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = op_idx_q;
        wr_tag_en = 1'b0;
        wr_tag    = op_tag_q;
        wr_st     = LS_INV;
        clr_all   = 1'b0;
        bst_start = 1'b0;
        bst_base  = {b_tag, b_idx, {OFF_W{1'b0}}};
        unique case (state_q)
            ST_IDLE: begin
                if (snp_valid_i) begin
                    if (snp_hit && a_st == LS_MOD) begin
                        bst_start = 1'b1;
                        bst_base  = {a_tag, snp_idx, {OFF_W{1'b0}}};
                        op_idx_d  = snp_idx;
                        op_st_d   = snp_new_st;
                        state_d   = ST_SNP_WB;
                    end else if (snp_hit) begin
                        wr_en  = 1'b1;
                        wr_idx = snp_idx;
                        wr_st  = snp_new_st;
                    end
                end else if (invd_i) begin
                    clr_all = 1'b1;
                end else if (flush_i || wbinvd_i) begin
                    op_idx_d = '0;
                    state_d  = ST_WALK;
                end else if (repl_valid_i) begin
                    op_idx_d = repl_idx_i;
                    op_tag_d = repl_tag_i;
                    op_st_d  = line_st_e'(repl_state_i);
                    if (b_st == LS_MOD) begin
                        bst_start = 1'b1;
                        state_d   = ST_REPL_WB;
                    end else begin
                        wr_en     = 1'b1;
                        wr_idx    = repl_idx_i;
                        wr_tag_en = 1'b1;
                        wr_tag    = repl_tag_i;
                        wr_st     = line_st_e'(repl_state_i);
                    end
                end
            end
            ST_SNP_WB: begin
                if (bst_done) begin
                    wr_en   = 1'b1;
                    wr_st   = op_st_q;
                    state_d = ST_IDLE;
                end
            end
            ST_WALK: begin
                if (b_st == LS_MOD) begin
                    bst_start = 1'b1;
                    state_d   = ST_WALK_WB;
                end else begin
                    wr_en = 1'b1;
                    if (walk_last) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        op_idx_d = op_idx_q + 1'b1;
                    end
                end
            end
            ST_WALK_WB: begin
                if (bst_done) begin
                    wr_en = 1'b1;
                    if (walk_last) begin
                        state_d = ST_IDLE;
                        done_d  = 1'b1;
                    end else begin
                        op_idx_d = op_idx_q + 1'b1;
                        state_d  = ST_WALK;
                    end
                end
            end
            ST_REPL_WB: begin
                if (bst_done) begin
                    wr_en     = 1'b1;
                    wr_tag_en = 1'b1;
                    wr_st     = op_st_q;
                    state_d   = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign req_rdy_o   = (state_q == ST_IDLE);
    assign busy_o      = (state_q == ST_WALK) || (state_q == ST_WALK_WB);
    assign rsp_valid_o = rsp_vld_q;
    assign rsp_hit_o   = rsp_hit_q;
    assign rsp_hitm_o  = rsp_hitm_q;
    assign rsp_state_o = rsp_st_q;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(snp_valid_i && req_rdy_o)); // R2
    AST_HITM_HAS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_hitm_o |-> (rsp_hit_o && rsp_state_o == 2'b11)); // R3
    AST_HITM_STARTS_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_hitm_o) |-> wb_valid_o); // R3
    AST_NO_RDY_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_valid_o |-> !req_rdy_o); // R10
    AST_NO_RDY_IN_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> !req_rdy_o); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R7
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ($past(busy_o) && !busy_o)); // R7
endmodule

// File: tb/mesi_snoop_ctrl_tb.sv
module mesi_snoop_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snp_valid = 1'b0;
    logic [31:0] snp_addr = '0;
    logic        snp_inv = 1'b0;
    logic        snp_internal = 1'b0;
    logic        req_rdy, rsp_valid, rsp_hit, rsp_hitm;
    logic [1:0]  rsp_state;
    logic        flush = 1'b0, wbinvd = 1'b0, invd = 1'b0;
    logic        repl_valid = 1'b0;
    logic [3:0]  repl_idx = '0;
    logic [22:0] repl_tag = '0;
    logic [1:0]  repl_state = '0;
    logic        busy, done;
    logic        wb_valid, wb_last;
    logic [31:0] wb_addr;
    logic        wb_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    logic        hold_vld = 1'b0;
    logic [31:0] hold_addr = '0;
    int          beat_in_line = 0;
    int          ack_cnt = 0;

    always #10 clk = ~clk;

    mesi_snoop_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .snp_valid_i(snp_valid), .snp_addr_i(snp_addr), .snp_inv_i(snp_inv),
        .snp_internal_i(snp_internal), .req_rdy_o(req_rdy), .rsp_valid_o(rsp_valid),
        .rsp_hit_o(rsp_hit), .rsp_hitm_o(rsp_hitm), .rsp_state_o(rsp_state),
        .flush_i(flush), .wbinvd_i(wbinvd), .invd_i(invd),
        .repl_valid_i(repl_valid), .repl_idx_i(repl_idx), .repl_tag_i(repl_tag),
        .repl_state_i(repl_state), .busy_o(busy), .done_o(done),
        .wb_valid_o(wb_valid), .wb_addr_o(wb_addr), .wb_last_o(wb_last), .wb_ack_i(wb_ack)
    );

    task automatic check(input logic ok, input string rq, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, got, exp);
        end
    endtask

    function automatic logic [31:0] line_addr(input logic [22:0] tag, input logic [3:0] idx);
        return {tag, idx, 5'h00};
    endfunction

    // Driver side of the scoreboard: four expected beats per written-back line
    task automatic expect_wb(input logic [22:0] tag, input logic [3:0] idx);
        for (int b = 0; b < 4; b++) exp_q.push_back(line_addr(tag, idx) + 32'(b * 8));
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!req_rdy) @(negedge clk);
    endtask

    // Monitor: drives the ack pattern and compares accepted beats with the queue
    always @(negedge clk) begin
        ack_cnt++;
        wb_ack = (ack_cnt % 3) != 0;
        if (hold_vld) begin
            check(wb_valid && wb_addr == hold_addr, "R6 beat held", {32'h0, wb_addr}, {32'h0, hold_addr});
            hold_vld = 1'b0;
        end
        if (wb_valid && !wb_ack) begin
            hold_vld  = 1'b1;
            hold_addr = wb_addr;
        end
        if (wb_valid && wb_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected beat", {32'h0, wb_addr}, 64'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(wb_addr == e, "R6 beat address", {32'h0, wb_addr}, {32'h0, e});
                check(wb_last == (beat_in_line == 3), "R6 last flag", {63'h0, wb_last},
                      {63'h0, beat_in_line == 3});
                beat_in_line = (beat_in_line + 1) % 4;
            end
        end
    end

    task automatic snoop(input logic [22:0] tag, input logic [3:0] idx, input logic inv,
                         input logic internal, input logic eh, input logic ehm,
                         input logic [1:0] est, input string rq);
        wait_ready();
        if (ehm) expect_wb(tag, idx);
        snp_addr = line_addr(tag, idx) + 32'h4;
        snp_inv = inv;
        snp_internal = internal;
        snp_valid = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0;
        check(rsp_valid && rsp_hit == eh && rsp_hitm == ehm && rsp_state == est, rq,
              {59'h0, rsp_valid, rsp_hit, rsp_hitm, rsp_state},
              {59'h0, 1'b1, eh, ehm, est});
    endtask

    task automatic replace(input logic [3:0] idx, input logic [22:0] tag, input logic [1:0] st);
        wait_ready();
        repl_idx = idx; repl_tag = tag; repl_state = st; repl_valid = 1'b1;
        @(negedge clk);
        repl_valid = 1'b0;
    endtask

    task automatic probe_miss(input logic [22:0] tag, input logic [3:0] idx, input string rq);
        snoop(tag, idx, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00, rq);
    endtask

    task automatic run_walk(input logic use_flush, input string rq);
        int n;
        wait_ready();
        if (use_flush) flush = 1'b1; else wbinvd = 1'b1;
        @(negedge clk);
        flush = 1'b0; wbinvd = 1'b0;
        check(busy && !req_rdy, {rq, " busy"}, {62'h0, busy, req_rdy}, 64'h2);
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        check(done && !busy, {rq, " done"}, {62'h0, done, busy}, 64'h2);
        @(negedge clk);
        check(!done, {rq, " done one cycle"}, {63'h0, done}, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_rdy && !busy && !done && !wb_valid && !rsp_valid, "R1 reset outputs",
              {59'h0, req_rdy, busy, done, wb_valid, rsp_valid}, 64'h10);
        probe_miss(23'h1234, 4'd0, "R1 line invalid after reset");

        // R2 / R12: exclusive line under external inquire
        replace(4'd1, 23'h00AA, 2'b10);
        snoop(23'h00AA, 4'd1, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, "R12 E reported, R2 downgrade");
        snoop(23'h00AA, 4'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01, "R2 became S");
        probe_miss(23'h00AA, 4'd1, "R2 INV=1 invalidated");

        // R3: modified line under external inquire
        replace(4'd3, 23'h0BEE, 2'b11);
        snoop(23'h0BEE, 4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, "R3 hitm INV=0");
        snoop(23'h0BEE, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R3 shared after writeback");
        replace(4'd3, 23'h0C0C, 2'b11);
        snoop(23'h0C0C, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 2'b11, "R9 S victim replaced, R3 hitm INV=1");
        probe_miss(23'h0C0C, 4'd3, "R3 invalid after INV=1");

        // R4: internal snoops
        replace(4'd4, 23'h0044, 2'b10);
        snoop(23'h0044, 4'd4, 1'b0, 1'b1, 1'b1, 1'b0, 2'b10, "R4 internal hit E");
        probe_miss(23'h0044, 4'd4, "R4 internal leaves invalid");
        replace(4'd4, 23'h0045, 2'b11);
        snoop(23'h0045, 4'd4, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11, "R4 internal hit M");
        probe_miss(23'h0045, 4'd4, "R4 invalid after writeback");

        // R5: tag mismatch
        replace(4'd6, 23'h0066, 2'b01);
        probe_miss(23'h0067, 4'd6, "R5 tag mismatch miss");
        snoop(23'h0066, 4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R5 state unchanged");

        // R9: modified victim
        replace(4'd8, 23'h0F0F, 2'b11);
        expect_wb(23'h0F0F, 4'd8);
        replace(4'd8, 23'h0ABC, 2'b10);
        snoop(23'h0ABC, 4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 2'b10, "R9 new line installed");
        probe_miss(23'h0F0F, 4'd8, "R9 old tag gone");

        // R10: requests during a writeback are ignored
        replace(4'd10, 23'h0101, 2'b11);
        wait_ready();
        expect_wb(23'h0101, 4'd10);
        snp_addr = line_addr(23'h0101, 4'd10); snp_inv = 1'b1; snp_internal = 1'b0; snp_valid = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0;
        repl_idx = 4'd11; repl_tag = 23'h0111; repl_state = 2'b10; repl_valid = 1'b1;
        @(negedge clk);
        check(!req_rdy, "R10 not ready during burst", {63'h0, req_rdy}, 64'h0);
        repl_valid = 1'b0;
        probe_miss(23'h0111, 4'd11, "R10 replacement ignored");

        // R7: flush walk
        replace(4'd2, 23'h0202, 2'b11);
        replace(4'd5, 23'h0505, 2'b11);
        replace(4'd15, 23'h0F15, 2'b11);
        replace(4'd7, 23'h0707, 2'b10);
        replace(4'd9, 23'h0909, 2'b01);
        expect_wb(23'h0202, 4'd2);
        expect_wb(23'h0505, 4'd5);
        expect_wb(23'h0F15, 4'd15);
        run_walk(1'b1, "R7 flush");
        probe_miss(23'h0202, 4'd2, "R7 flushed 2");
        probe_miss(23'h0707, 4'd7, "R7 flushed 7");
        probe_miss(23'h0909, 4'd9, "R7 flushed 9");
        probe_miss(23'h0F15, 4'd15, "R7 flushed 15");

        // R7: writeback-and-invalidate walk
        replace(4'd12, 23'h0C12, 2'b11);
        replace(4'd0, 23'h0C00, 2'b11);
        expect_wb(23'h0C00, 4'd0);
        expect_wb(23'h0C12, 4'd12);
        run_walk(1'b0, "R7 wbinvd");
        probe_miss(23'h0C00, 4'd0, "R7 wbinvd 0");
        probe_miss(23'h0C12, 4'd12, "R7 wbinvd 12");

        // R8: invalidate only
        replace(4'd3, 23'h0333, 2'b11);
        replace(4'd13, 23'h0313, 2'b10);
        wait_ready();
        invd = 1'b1;
        @(negedge clk);
        invd = 1'b0;
        check(req_rdy && !wb_valid, "R8 no writeback", {62'h0, req_rdy, wb_valid}, 64'h2);
        probe_miss(23'h0333, 4'd3, "R8 M dropped");
        probe_miss(23'h0313, 4'd13, "R8 E dropped");

        // R11: priorities
        replace(4'd11, 23'h0B11, 2'b10);
        wait_ready();
        snp_addr = line_addr(23'h0B11, 4'd11); snp_inv = 1'b0; snp_internal = 1'b0;
        snp_valid = 1'b1; invd = 1'b1;
        @(negedge clk);
        snp_valid = 1'b0; invd = 1'b0;
        check(rsp_valid && rsp_hit, "R11 snoop over invd", {62'h0, rsp_valid, rsp_hit}, 64'h3);
        snoop(23'h0B11, 4'd11, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, "R11 invd dropped");
        replace(4'd13, 23'h0D13, 2'b11);
        wait_ready();
        invd = 1'b1; flush = 1'b1;
        @(negedge clk);
        invd = 1'b0; flush = 1'b0;
        check(!busy && req_rdy, "R11 invd over flush", {62'h0, busy, req_rdy}, 64'h1);
        probe_miss(23'h0D13, 4'd13, "R11 invd applied");
        wait_ready();
        flush = 1'b1;
        repl_idx = 4'd14; repl_tag = 23'h0E14; repl_state = 2'b10; repl_valid = 1'b1;
        @(negedge clk);
        flush = 1'b0; repl_valid = 1'b0;
        while (busy) @(negedge clk);
        probe_miss(23'h0E14, 4'd14, "R11 replacement dropped");

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R6 all expected beats seen", 64'(exp_q.size()), 64'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule